// File: doc/BRIEF.md
# Two-Stage Selectable Clock Divider Tree

This block turns one of two oscillator tick streams into several slower tick streams. A source select picks either the slow or the fast input stream. A single pre-divider divides the chosen stream. Its output then fans out to two families of second-stage dividers: general output dividers and counter-clock dividers. Each family has its own set of ratios, and each divider has its own select. The overall division of any output is the pre-divide ratio multiplied by that output's second-stage ratio.

All logic runs on one system clock. Every input tick and every output tick is a one-cycle enable, not a derived clock. Each divider stage is a small two-state machine. In `ST_ALIGNED` the stage sits on a period boundary with its count at zero. In `ST_COUNTING` it is part way through a period. A tick in `ST_ALIGNED` either fires at once (ratio 1, the stage stays aligned) or moves to `ST_COUNTING` with a count of one. A tick in `ST_COUNTING` either advances the count or, on the last tick of the period, fires and returns to `ST_ALIGNED`. A clear from a select change, or from reset, forces `ST_ALIGNED` from either state.

Any change of a select value clears the stage it controls and every stage downstream of it, so the next pulse comes a full new period later. The blocks that consume the ticks use them as clock enables.

Top module: `clkdiv_tree`

## Requirements
- R1: `src_sel` = 1 routes `fast_tick` into the pre-divider and `src_sel` = 0 routes `slow_tick`. The unselected input has no effect.
- R2: The `pre_sel` codes 0, 1, 2 and 3 divide the selected stream by 1, 2, 4 and 8.
- R3: Output divider i is controlled by `out_sel[3i+2:3i]`. Its codes 0 to 7 divide the pre-divider pulses by 1, 2, 3, 4, 8, 12, 24 and 64, and the pulses are evenly spaced for every ratio, including the odd one.
- R4: Counter divider j is controlled by `cnt_sel[3j+2:3j]`. Its codes 0 to 5 divide the pre-divider pulses by 1, 4, 12, 24, 64 and 4096, and codes 6 and 7 divide by 1.
- R5: With steady selects, the spacing between pulses on any output, in source ticks, is the product of the pre-divide ratio and that output's second-stage ratio (for example 8 × 4096 = 32768).
- R6: Every output pulse is one system clock wide. A source tick sampled at clock edge e gives a pre-divider pulse after edge e and a second-stage pulse after edge e+1. With ratio 1 in both stages, every source tick appears on the output two cycles later.
- R7: A change of `src_sel` or `pre_sel` clears the pre-divider and all second stages in the clock cycle in which the new value is first seen. A change of one second-stage select clears only that divider. A tick that arrives in the clearing cycle is discarded, all cleared outputs are low in the next cycle, and the first new pulse comes after a full new period.
- R8: `rst_n` low at a clock edge clears every divider count and forces every output low from the next cycle on. After release, counting starts from zero without a spurious clear.
- R9: Changing the select of one second-stage divider does not disturb the pulse spacing or phase of any other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Slow oscillator tick, one-cycle enable |
| fast_tick | input | 1 | Fast oscillator tick, one-cycle enable |
| src_sel | input | 1 | Source select: 1 picks the fast tick, 0 picks the slow tick |
| pre_sel | input | 2 | Pre-divider ratio code |
| out_sel | input | 3*NUM_OUT | Per-output ratio codes, 3 bits each, output 0 in the lowest bits |
| cnt_sel | input | 3*NUM_CNT | Per-counter ratio codes, 3 bits each, counter 0 in the lowest bits |
| out_tick | output | NUM_OUT | General output tick pulses |
| cnt_tick | output | NUM_CNT | Counter-clock tick pulses |

## Verification
The assertions assume that every input changes only between clock edges and is synchronous to `clk`. They also assume that the select inputs hold known values from the first reset edge onward, because the registers that detect select changes keep following the selects through reset. The bench meets these assumptions by driving all selects from time zero and applying every change on a falling edge. It derives the slow tick from its own cycle counter, so that tick updates only at rising edges, and it holds the fast tick high so that the fast source ticks in every cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int PRE_SEL_W = 2;
    localparam int SEL_W     = 3;
    localparam int PRE_W     = 4;
    localparam int OUT_W     = 7;
    localparam int CNT_W     = 13;

    typedef enum logic {
        ST_ALIGNED,
        ST_COUNTING
    } div_state_e;

    function automatic logic [PRE_W-1:0] pre_ratio(input logic [PRE_SEL_W-1:0] code);
        return PRE_W'(1) << code;
    endfunction

    function automatic logic [OUT_W-1:0] out_ratio(input logic [SEL_W-1:0] code);
        logic [OUT_W-1:0] r;
        unique case (code)
            3'd0: r = OUT_W'(1);
            3'd1: r = OUT_W'(2);
            3'd2: r = OUT_W'(3);
            3'd3: r = OUT_W'(4);
            3'd4: r = OUT_W'(8);
            3'd5: r = OUT_W'(12);
            3'd6: r = OUT_W'(24);
            default: r = OUT_W'(64);
        endcase
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] cnt_ratio(input logic [SEL_W-1:0] code);
        logic [CNT_W-1:0] r;
        unique case (code)
            3'd1: r = CNT_W'(4);
            3'd2: r = CNT_W'(12);
            3'd3: r = CNT_W'(24);
            3'd4: r = CNT_W'(64);
            3'd5: r = CNT_W'(4096);
            default: r = CNT_W'(1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clkdiv_ratio_stage.sv
module clkdiv_ratio_stage
    import clkdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         pulse
);

    div_state_e   state_q, state_d;
    logic [W-1:0] count_q, count_d;
    logic         fire;

    // Next-state logic of the period tracker
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        fire    = 1'b0;
        if (clear) begin
            state_d = ST_ALIGNED;
            count_d = '0;
        end else if (tick) begin
            unique case (state_q)
                ST_ALIGNED: begin
                    if (ratio <= W'(1)) begin
                        fire = 1'b1;
                    end else begin
                        count_d = W'(1);
                        state_d = ST_COUNTING;
                    end
                end
                ST_COUNTING: begin
                    if (count_q >= ratio - W'(1)) begin
                        fire    = 1'b1;
                        count_d = '0;
                        state_d = ST_ALIGNED;
                    end else begin
                        count_d = count_q + W'(1);
                    end
                end
                default: begin
                    state_d = ST_ALIGNED;
                    count_d = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ALIGNED;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // Output register: one-cycle enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= fire;
        end
    end

endmodule

// File: rtl/clkdiv_sel_watch.sv
module clkdiv_sel_watch #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic [W-1:0] sel,
    output logic         changed
);

    logic [W-1:0] last_q;

    // Follows the select through reset as well, so a release never
    // looks like a select change.
    always_ff @(posedge clk) begin
        last_q <= sel;
    end

    assign changed = (sel != last_q);

endmodule

// File: rtl/clkdiv_tree.sv
module clkdiv_tree
    import clkdiv_pkg::*;
#(
    parameter int NUM_OUT = 2,
    parameter int NUM_CNT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     slow_tick,
    input  logic                     fast_tick,
    input  logic                     src_sel,
    input  logic [PRE_SEL_W-1:0]     pre_sel,
    input  logic [NUM_OUT*SEL_W-1:0] out_sel,
    input  logic [NUM_CNT*SEL_W-1:0] cnt_sel,
    output logic [NUM_OUT-1:0]       out_tick,
    output logic [NUM_CNT-1:0]       cnt_tick
);

    localparam int UP_W = 1 + PRE_SEL_W;

    logic src_tick;
    logic up_chg;
    logic pre_pulse;

    assign src_tick = src_sel ? fast_tick : slow_tick;

    clkdiv_sel_watch #(.W(UP_W)) u_up_watch (
        .clk     (clk),
        .sel     ({src_sel, pre_sel}),
        .changed (up_chg)
    );

    clkdiv_ratio_stage #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (up_chg),
        .tick  (src_tick),
        .ratio (pre_ratio(pre_sel)),
        .pulse (pre_pulse)
    );

    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
            logic own_chg;

            clkdiv_sel_watch #(.W(SEL_W)) u_watch (
                .clk     (clk),
                .sel     (out_sel[i*SEL_W +: SEL_W]),
                .changed (own_chg)
            );

            clkdiv_ratio_stage #(.W(OUT_W)) u_div (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (up_chg | own_chg),
                .tick  (pre_pulse),
                .ratio (out_ratio(out_sel[i*SEL_W +: SEL_W])),
                .pulse (out_tick[i])
            );
        end

        for (genvar j = 0; j < NUM_CNT; j++) begin : g_cnt
            logic own_chg;

            clkdiv_sel_watch #(.W(SEL_W)) u_watch (
                .clk     (clk),
                .sel     (cnt_sel[j*SEL_W +: SEL_W]),
                .changed (own_chg)
            );

            clkdiv_ratio_stage #(.W(CNT_W)) u_div (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (up_chg | own_chg),
                .tick  (pre_pulse),
                .ratio (cnt_ratio(cnt_sel[j*SEL_W +: SEL_W])),
                .pulse (cnt_tick[j])
            );
        end
    endgenerate

endmodule

// File: rtl/clkdiv_tree_chk.sv
module clkdiv_tree_chk
    import clkdiv_pkg::*;
#(
    parameter int NUM_OUT = 2,
    parameter int NUM_CNT = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     slow_tick,
    input logic                     fast_tick,
    input logic                     src_sel,
    input logic [PRE_SEL_W-1:0]     pre_sel,
    input logic [NUM_OUT*SEL_W-1:0] out_sel,
    input logic [NUM_CNT*SEL_W-1:0] cnt_sel,
    input logic                     pre_pulse,
    input logic [NUM_OUT-1:0]       out_tick,
    input logic [NUM_CNT-1:0]       cnt_tick
);

    AST_PRE_FROM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        pre_pulse |-> $past(src_sel ? fast_tick : slow_tick)); // R1

    AST_UPSTREAM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ({src_sel, pre_sel} != $past({src_sel, pre_sel}))
        |=> (!pre_pulse && out_tick == '0 && cnt_tick == '0)); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!pre_pulse && out_tick == '0 && cnt_tick == '0)); // R8

    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_out_chk
            AST_OUT_FROM_PRE: assert property (@(posedge clk) disable iff (!rst_n)
                out_tick[i] |-> $past(pre_pulse)); // R6

            AST_OUT_UNIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                (out_sel[i*SEL_W +: SEL_W] == '0 && $stable(out_sel[i*SEL_W +: SEL_W])
                 && $stable({src_sel, pre_sel}) && pre_pulse) |=> out_tick[i]); // R3
        end

        for (genvar j = 0; j < NUM_CNT; j++) begin : g_cnt_chk
            AST_CNT_FROM_PRE: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_tick[j] |-> $past(pre_pulse)); // R6

            AST_CNT_UNIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                ((cnt_sel[j*SEL_W +: SEL_W] == 3'd0 || cnt_sel[j*SEL_W +: SEL_W] >= 3'd6)
                 && $stable(cnt_sel[j*SEL_W +: SEL_W])
                 && $stable({src_sel, pre_sel}) && pre_pulse) |=> cnt_tick[j]); // R4
        end
    endgenerate

endmodule

bind clkdiv_tree clkdiv_tree_chk #(.NUM_OUT(NUM_OUT), .NUM_CNT(NUM_CNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .fast_tick (fast_tick),
    .src_sel   (src_sel),
    .pre_sel   (pre_sel),
    .out_sel   (out_sel),
    .cnt_sel   (cnt_sel),
    .pre_pulse (pre_pulse),
    .out_tick  (out_tick),
    .cnt_tick  (cnt_tick)
);

// File: tb/clkdiv_tree_test.sv
module clkdiv_tree_test;

    localparam int     CLK_PERIOD = 10;
    localparam longint WATCHDOG   = 190000;
    localparam int     NV         = 8;

    // {src, pre, out0, out1, cnt0, cnt1}; expected gaps derive from it below
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 2'd0, 3'd0, 3'd1, 3'd0, 3'd1},
        {1'b1, 2'd1, 3'd2, 3'd3, 3'd2, 3'd3},
        {1'b1, 2'd2, 3'd4, 3'd5, 3'd4, 3'd6},
        {1'b1, 2'd3, 3'd6, 3'd7, 3'd7, 3'd1},
        {1'b0, 2'd0, 3'd2, 3'd7, 3'd5, 3'd0},
        {1'b1, 2'd3, 3'd0, 3'd4, 3'd5, 3'd2},
        {1'b0, 2'd1, 3'd3, 3'd6, 3'd3, 3'd4},
        {1'b1, 2'd0, 3'd7, 3'd2, 3'd1, 3'd5}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       slow_tick;
    logic       fast_tick;
    logic       src_sel;
    logic [1:0] pre_sel;
    logic [5:0] out_sel;
    logic [5:0] cnt_sel;
    logic [1:0] out_tick;
    logic [1:0] cnt_tick;
    logic [3:0] all_ticks;

    longint cyc = 0;
    int     checks = 0;
    int     errors = 0;
    longint gaps [4];

    assign slow_tick = (cyc % 64'd3 == 64'd0);
    assign all_ticks = {cnt_tick, out_tick};

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    clkdiv_tree uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .fast_tick (fast_tick),
        .src_sel   (src_sel),
        .pre_sel   (pre_sel),
        .out_sel   (out_sel),
        .cnt_sel   (cnt_sel),
        .out_tick  (out_tick),
        .cnt_tick  (cnt_tick)
    );

    function automatic longint e_pre(input logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic longint e_out(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 3;
            3'd3: return 4;
            3'd4: return 8;
            3'd5: return 12;
            3'd6: return 24;
            default: return 64;
        endcase
    endfunction

    function automatic longint e_cnt(input logic [2:0] c);
        case (c)
            3'd1: return 4;
            3'd2: return 12;
            3'd3: return 24;
            3'd4: return 64;
            3'd5: return 4096;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [14:0] v);
        src_sel = v[14];
        pre_sel = v[13:12];
        out_sel = {v[8:6], v[11:9]};
        cnt_sel = {v[2:0], v[5:3]};
    endtask

    task automatic measure_gap(input int idx, output longint gap);
        longint t1 = 0;
        int     seen = 0;
        gap = 0;
        while (seen < 2) begin
            @(negedge clk);
            if (all_ticks[idx]) begin
                if (seen == 0) t1 = cyc;
                else gap = cyc - t1;
                seen++;
            end
        end
    endtask

    task automatic run_vec(input logic [14:0] v, input int n);
        longint base;
        longint pre;
        @(negedge clk);
        apply(v);
        base = v[14] ? 64'd1 : 64'd3;
        pre  = e_pre(v[13:12]);
        fork
            measure_gap(0, gaps[0]);
            measure_gap(1, gaps[1]);
            measure_gap(2, gaps[2]);
            measure_gap(3, gaps[3]);
        join
        chk($sformatf("R5 R1 R2 R3 vec %0d out0", n), gaps[0], base * pre * e_out(v[11:9]));
        chk($sformatf("R5 R1 R2 R3 vec %0d out1", n), gaps[1], base * pre * e_out(v[8:6]));
        chk($sformatf("R5 R1 R2 R4 vec %0d cnt0", n), gaps[2], base * pre * e_cnt(v[5:3]));
        chk($sformatf("R5 R1 R2 R4 vec %0d cnt1", n), gaps[3], base * pre * e_cnt(v[2:0]));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        longint k;
        longint t_a;
        longint t_b;
        longint t1;

        rst_n     = 1'b0;
        fast_tick = 1'b1;
        apply(15'd0);

        // R8: outputs low while in reset
        repeat (3) begin
            @(negedge clk);
            chk("R8 outputs in reset", longint'(all_ticks), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R6 / R1: slow source, all ratios 1, output follows tick two cycles later
        repeat (8) @(negedge clk);
        for (int n = 0; n < 9; n++) begin
            @(negedge clk);
            chk("R6 R1 slow pass-through out0", longint'(out_tick[0]),
                longint'((cyc - 2) % 3 == 0));
            chk("R6 R1 slow pass-through cnt1", longint'(cnt_tick[1]),
                longint'((cyc - 2) % 3 == 0));
        end

        // R6: fast source, ratio 1 everywhere, pulse every cycle
        @(negedge clk);
        apply({1'b1, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0});
        repeat (4) @(negedge clk);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk("R6 divide-by-1 every tick", longint'(all_ticks), 15);
        end

        // R7: upstream change clears everything; first pulse after a full period
        @(negedge clk);
        k = cyc;
        apply({1'b1, 2'd1, 3'd2, 3'd0, 3'd1, 3'd0});
        t_a = -1;
        t_b = -1;
        for (int n = 1; n <= 14; n++) begin
            @(negedge clk);
            if (n == 1) chk("R7 outputs low after clear", longint'(all_ticks), 0);
            if (out_tick[0] && t_a < 0) t_a = cyc;
            if (cnt_tick[0] && t_b < 0) t_b = cyc;
        end
        chk("R7 first out0 pulse after change", t_a - k, 8);
        chk("R7 first cnt0 pulse after change", t_b - k, 10);

        // R9: changing out0 select leaves out1 phase untouched
        @(negedge clk);
        apply({1'b1, 2'd0, 3'd0, 3'd3, 3'd0, 3'd0});
        repeat (12) @(negedge clk);
        while (!out_tick[1]) @(negedge clk);
        t1 = cyc;
        apply({1'b1, 2'd0, 3'd1, 3'd3, 3'd0, 3'd0});
        t_a = -1;
        t_b = -1;
        for (int n = 1; n <= 6; n++) begin
            @(negedge clk);
            if (out_tick[0] && t_a < 0) t_a = cyc;
            if (out_tick[1] && t_b < 0) t_b = cyc;
        end
        chk("R9 out1 spacing kept across out0 change", t_b - t1, 4);
        chk("R7 out0 fresh period after own change", t_a - t1, 3);

        // R8: reset mid-run, then restart from zero
        @(negedge clk);
        apply({1'b1, 2'd0, 3'd0, 3'd0, 3'd0, 3'd0});
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 outputs low after reset edge", longint'(all_ticks), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 no pulse one cycle after release", longint'(all_ticks), 0);
        @(negedge clk);
        chk("R8 pulses resume two cycles after release", longint'(all_ticks), 15);

        // Table walk: R1 to R5 across source, pre and second-stage codes
        for (int n = 0; n < NV; n++) begin
            run_vec(VEC[n], n);
        end

        // Sweep of every second-stage code, fast source, no pre-divide (R3, R4)
        for (int c = 0; c < 8; c++) begin
            run_vec({1'b1, 2'd0, 3'(c), 3'(7 - c), 3'(c), 3'(7 - c)}, 100 + c);
        end

        finish_run();
    end

endmodule